// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Converter

This block turns an unsigned binary word, 16 bits by default, into packed decimal digits, six digits held as three bytes by default. One bit is handled per clock. On each step the binary word moves left by one place, and the bit that leaves its top end feeds a decimal accumulator. That accumulator is then replaced by twice its value plus the bit. The doubling is done in decimal, digit by digit: a digit whose doubled value goes past nine is corrected by adding six, and it passes a carry to the digit above.

A user pulses the start input while the block is idle and presents the binary word in the same cycle. The block raises busy, clears the accumulator, runs exactly one step for each input bit, and then pulses done for one cycle. The packed result stays on the output until the next accepted start.

Top module: `bcd_seq_conv`

## Requirements
- R1: After reset, busy and done are low and the packed output is all zeros.
- R2: A start seen while busy is low is accepted. In the following cycle busy is high and the packed output reads zero.
- R3: Busy stays high for exactly BIN_W cycles (16 by default). Done is then high for exactly one cycle, with busy low.
- R4: When done is high, the packed output equals the decimal value of the word captured at the accepted start. Digit k sits in bits 4k+3 down to 4k, and the least significant digit is in bits 3:0.
- R5: Every 4-bit digit of the packed output is 9 or less in every cycle.
- R6: A start seen while busy is high is ignored. It changes neither the result nor the number of busy cycles.
- R7: Outside a conversion, with start low, the packed output does not change, whatever happens on the binary input.
- R8: After k steps (1 ≤ k < BIN_W), the packed output is the decimal value of the top k bits of the captured word. Each step therefore gives twice the previous decimal value, plus 0 or 1.
- R9: Per-digit correction is exact at the range limits. An input of 0 gives 000000, 65535 gives 065535, 9999 gives 009999 and 10000 gives 010000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; accepted only while idle |
| bin_i | input | BIN_W | Binary word, sampled on an accepted start |
| busy_o | output | 1 | High while conversion steps run |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| bcd_o | output | 4*DIGITS | Packed decimal result, least significant digit in the low nibble |

## Verification
A wrong step count or a late step shows up as a busy window of the wrong length, or as an intermediate value that does not equal the decimal value of the word's top bits. Either is visible at the first step where it occurs, because the accumulator is on the output every cycle. A bad decimal correction produces a nibble above nine, or a value that is not twice the previous one. Such a fault is caught in the step where the offending digit first goes past four. Loss of the captured word, or acceptance of a start while busy, shows as a wrong final value on the done cycle.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    localparam int NIBBLE_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic                carry;
        logic [NIBBLE_W-1:0] digit;
    } digit_res_t;

    // One decimal digit: 2*d + cin, corrected back into 0..9 with carry out.
    function automatic digit_res_t dbl_digit(input logic [NIBBLE_W-1:0] d,
                                             input logic cin);
        digit_res_t         r;
        logic [NIBBLE_W:0]  s;
        s = {d, cin};
        if (s > 5'd9) begin
            r.digit = s[NIBBLE_W-1:0] + 4'd6;
            r.carry = 1'b1;
        end else begin
            r.digit = s[NIBBLE_W-1:0];
            r.carry = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
    import bcd_conv_pkg::*;
#(
    parameter int BIN_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(BIN_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BIN_W - 1);

    conv_state_e      state_q;
    logic [CNT_W-1:0] step_cnt_q;
    logic             done_q;

    assign load_o = start_i && (state_q == ST_IDLE);
    assign step_o = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_RUN;
                        step_cnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_cnt_q == LAST_STEP) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_cnt_q <= step_cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = step_o;
    assign done_o = done_q;

endmodule

// File: rtl/bcd_bin_shifter.sv
module bcd_bin_shifter #(
    parameter int BIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic             msb_o
);
    logic [BIN_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= bin_i;
        end else if (step_i) begin
            word_q <= {word_q[BIN_W-2:0], 1'b0};
        end
    end

    assign msb_o = word_q[BIN_W-1];

endmodule

// File: rtl/bcd_accum.sv
module bcd_accum
    import bcd_conv_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear_i,
    input  logic                       step_i,
    input  logic                       bit_i,
    output logic [NIBBLE_W*DIGITS-1:0] acc_o
);
    localparam int ACC_W = NIBBLE_W * DIGITS;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;

    // Ripple the decimal carry from the lowest digit upward; the shifted-out
    // bit enters as the carry into digit 0.
    always_comb begin
        logic       c;
        digit_res_t r;
        c       = bit_i;
        acc_nxt = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r = dbl_digit(acc_q[i*NIBBLE_W +: NIBBLE_W], c);
            acc_nxt[i*NIBBLE_W +: NIBBLE_W] = r.digit;
            c = r.carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= acc_nxt;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/bcd_seq_conv.sv
module bcd_seq_conv
    import bcd_conv_pkg::*;
#(
    parameter int BIN_W  = 16,
    parameter int DIGITS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [BIN_W-1:0]           bin_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NIBBLE_W*DIGITS-1:0] bcd_o
);
    logic load_w;
    logic step_w;
    logic msb_w;

    bcd_ctrl #(.BIN_W(BIN_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load_w),
        .step_o  (step_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    bcd_bin_shifter #(.BIN_W(BIN_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .step_i (step_w),
        .bin_i  (bin_i),
        .msb_o  (msb_w)
    );

    bcd_accum #(.DIGITS(DIGITS)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (load_w),
        .step_i  (step_w),
        .bit_i   (msb_w),
        .acc_o   (bcd_o)
    );

endmodule

// File: rtl/bcd_seq_conv_chk.sv
module bcd_seq_conv_chk #(
    parameter int BIN_W  = 16,
    parameter int DIGITS = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic [BIN_W-1:0]     bin_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [4*DIGITS-1:0]  bcd_o
);
    localparam int BC_W = $clog2(BIN_W + 2) + 1;

    function automatic longint unsigned dec_val(input logic [4*DIGITS-1:0] p);
        longint unsigned v = 0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            v = v * 10 + longint'(p[i*4 +: 4]);
        end
        return v;
    endfunction

    logic [BIN_W-1:0] cap_q;
    logic [BC_W-1:0]  busy_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q      <= '0;
            busy_cnt_q <= '0;
        end else begin
            if (start_i && !busy_o) cap_q <= bin_i;
            if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
            else        busy_cnt_q <= '0;
        end
    end

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && bcd_o == '0));

    a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_cnt_q == BC_W'(BIN_W)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r4_result: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (dec_val(bcd_o) == longint'(cap_q)));

    a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && busy_cnt_q < BC_W'(BIN_W - 1)) |=> busy_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(bcd_o));

    a_r8_step: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ((!busy_o && !done_o) ||
                    dec_val(bcd_o) == 2 * dec_val($past(bcd_o)) ||
                    dec_val(bcd_o) == 2 * dec_val($past(bcd_o)) + 1));

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            a_r5_digit_range: assert property (@(posedge clk) disable iff (rst)
                bcd_o[g*4 +: 4] <= 4'd9);
        end
    endgenerate

endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .bin_i   (bin_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .bcd_o   (bcd_o)
);

// File: tb/bcd_seq_conv_bench.sv
module bcd_seq_conv_bench;
    localparam int BIN_W  = 16;
    localparam int DIGITS = 6;
    localparam int OUT_W  = 4 * DIGITS;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [BIN_W-1:0] bin_i;
    logic             busy_o;
    logic             done_o;
    logic [OUT_W-1:0] bcd_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2ns clk = ~clk;

    bcd_seq_conv #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_bcd_seq_conv (
        .clk(clk), .rst(rst), .start_i(start_i), .bin_i(bin_i),
        .busy_o(busy_o), .done_o(done_o), .bcd_o(bcd_o)
    );

    function automatic logic [OUT_W-1:0] to_bcd(input longint unsigned v);
        logic [OUT_W-1:0] r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    // Runs one conversion; optionally pulses start mid-run with junk.
    task automatic convert(input logic [BIN_W-1:0] v, input bit poke);
        logic [BIN_W-1:0] top;
        start_i = 1'b1;
        bin_i   = v;
        @(negedge clk);
        start_i = 1'b0;
        bin_i   = ~v;
        check("R2 busy", busy_o, 1);
        check("R2 clear", bcd_o, 0);
        for (int k = 1; k <= BIN_W; k++) begin
            if (poke && k == 5) begin
                start_i = 1'b1;
                bin_i   = v ^ 16'h5a5a;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (k < BIN_W) begin
                top = v >> (BIN_W - k);
                check("R8 partial", bcd_o, to_bcd(longint'(top)));
                check("R3 busy", busy_o, 1);
                check("R3 no done", done_o, 0);
            end else begin
                check("R3 busy low", busy_o, 0);
                check("R3 done", done_o, 1);
                check(poke ? "R6 result" : "R4 result", bcd_o, to_bcd(longint'(v)));
            end
        end
        bin_i = $urandom;
        @(negedge clk);
        check("R3 done pulse", done_o, 0);
        check("R7 hold", bcd_o, to_bcd(longint'(v)));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst     = 1'b1;
        start_i = 1'b0;
        bin_i   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 bcd", bcd_o, 0);

        // R9 directed corner cases
        convert(16'd0, 0);
        check("R9 zero", bcd_o, 24'h000000);
        convert(16'd65535, 0);
        check("R9 max", bcd_o, 24'h065535);
        convert(16'd9999, 0);
        check("R9 9999", bcd_o, 24'h009999);
        convert(16'd10000, 0);
        check("R9 10000", bcd_o, 24'h010000);

        // R6 start while busy
        convert(16'd4321, 1);
        convert(16'd59999, 1);

        // R7 idle with changing input
        for (int i = 0; i < 8; i++) begin
            bin_i = $urandom;
            @(negedge clk);
            check("R7 idle", bcd_o, to_bcd(longint'(59999)));
            check("R7 busy", busy_o, 0);
        end

        for (int n = 0; n < 300; n++) begin
            convert(16'($urandom), ($urandom % 4) == 0);
        end
        finish_run();
    end

endmodule